// File: doc/BRIEF.md
# Branch Trace History Buffer

This block keeps a short history of the control transfers a processor has just taken, so that a debug host can see how execution reached its current point. Each retired transfer arrives as a one-cycle strobe carrying a class code, the address it left from and the address it went to, plus two qualifier flags: a zero-displacement flag and a reset-vector flag. A third flag marks exception entries of the completion type. Three enables pick which kinds of transfer are kept: ordinary branches, subroutine call and return, and exception traffic (exception return together with every exception or interrupt entry). Some transfers are never kept: conditional branches whose displacement is zero, and the jump to the reset vector.

The history is an eight-deep ring of source/destination pairs. A combinational read port takes an index and returns the matching pair, newest first. When continuous mode is off, a full ring overwrites its oldest pair. When continuous mode is on, filling the ring raises a stall request that holds the processor until the host acknowledges a drain. The drain empties the ring. Four such loads are captured, 32 pairs in total. After the fourth drain, capture stops until continuous mode is turned off.

Top module: `brtrace_hist`

## Requirements
- R1: After reset the entry count is 0, stall_req and cont_done are low, and every read index returns rd_valid low with zero addresses.
- R2: Class codes 0 (conditional), 1 (conditional with delay slot), 2 (unconditional relative or register-relative) and 3 (register-indirect jump) are recorded only while en_normal is high.
- R3: Class codes 4 (call, relative or indirect) and 5 (subroutine return) are recorded only while en_sub is high.
- R4: Class codes 6 (exception return) and 7 (exception or interrupt entry) are recorded only while en_exc is high.
- R5: A strobe with class 0 or 1 and ret_disp_zero high is never recorded. For every other class, ret_disp_zero has no effect.
- R6: A strobe with ret_reset_vec high is never recorded, whatever its class.
- R7: For class 7 with ret_completion high, the recorded source is ret_src plus INSN_BYTES (default 2). For any other class, ret_completion has no effect.
- R8: A recorded pair is readable from the cycle after its strobe edge. rd_idx 0 returns the newest pair. When rd_idx is not less than entry_count, rd_valid is low and the addresses read as zero.
- R9: With cont_mode low the ring keeps the latest DEPTH (8) pairs. entry_count saturates at 8, and each new pair displaces the oldest.
- R10: With cont_mode high, stall_req rises on the edge that writes the eighth pair. Strobes that arrive while stall_req is high are dropped.
- R11: ack_drain while stall_req is high empties the ring (entry_count 0) and lowers stall_req on the same edge.
- R12: After LOADS (4) drains in continuous mode, cont_done goes high and no strobe is recorded. Lowering cont_mode clears cont_done and the load count, and capture then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | A control transfer retired this cycle |
| ret_class | input | 3 | Transfer class code, 0 to 7 |
| ret_src | input | ADDR_W | Address of the transferring instruction |
| ret_dst | input | ADDR_W | Target address |
| ret_disp_zero | input | 1 | Branch displacement is zero |
| ret_reset_vec | input | 1 | Transfer is the jump to the reset vector |
| ret_completion | input | 1 | Exception entry is of the completion type |
| en_normal | input | 1 | Keep ordinary branches |
| en_sub | input | 1 | Keep subroutine call and return |
| en_exc | input | 1 | Keep exception return and entries |
| cont_mode | input | 1 | Continuous mode: stall on full instead of overwriting |
| ack_drain | input | 1 | Host has read the full ring |
| rd_idx | input | IDX_W | Read index, 0 is the newest pair |
| rd_valid | output | 1 | Indexed pair holds data |
| rd_src | output | ADDR_W | Recorded source of the indexed pair |
| rd_dst | output | ADDR_W | Recorded destination of the indexed pair |
| entry_count | output | CNT_W | Pairs currently held |
| stall_req | output | 1 | Request to hold the processor for a drain |
| cont_done | output | 1 | All continuous-mode loads have been captured |

## Verification
Every result of a strobe or a drain is due exactly one clock edge after the cycle in which that input was held: the count, the stall request, the done flag and the ring contents all update on that edge. The read port adds no further delay. The bench drives each input on a falling edge and lets one rising edge pass. It samples on the next falling edge, and only then sweeps the read index. Each index is settled for a fraction of a nanosecond before it is compared with the expected newest-first list.

// File: rtl/brtrace_pkg.sv
package brtrace_pkg;

  typedef enum logic [2:0] {
    BR_COND      = 3'd0,
    BR_COND_DS   = 3'd1,
    BR_UNCOND    = 3'd2,
    BR_JUMP      = 3'd3,
    BR_CALL      = 3'd4,
    BR_RETURN    = 3'd5,
    BR_EXC_RET   = 3'd6,
    BR_EXC_ENTRY = 3'd7
  } br_class_e;

  typedef enum logic [1:0] {
    GRP_NORMAL = 2'd0,
    GRP_SUB    = 2'd1,
    GRP_EXC    = 2'd2
  } br_group_e;

  function automatic br_group_e class_group(br_class_e c);
    case (c)
      BR_CALL, BR_RETURN:        return GRP_SUB;
      BR_EXC_RET, BR_EXC_ENTRY:  return GRP_EXC;
      default:                   return GRP_NORMAL;
    endcase
  endfunction

  function automatic logic is_conditional(br_class_e c);
    return (c == BR_COND) || (c == BR_COND_DS);
  endfunction

  // Physical slot of the pair that is idx places older than the newest one.
  function automatic int ring_slot(int wptr, int idx, int depth);
    return (wptr - 1 - idx + 2 * depth) % depth;
  endfunction

endpackage

// File: rtl/brtrace_filter.sv
module brtrace_filter
  import brtrace_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 2
) (
  input  logic              ret_valid,
  input  logic [2:0]        ret_class,
  input  logic [ADDR_W-1:0] ret_src,
  input  logic              ret_disp_zero,
  input  logic              ret_reset_vec,
  input  logic              ret_completion,
  input  logic              en_normal,
  input  logic              en_sub,
  input  logic              en_exc,
  output logic              accept,
  output logic [ADDR_W-1:0] src_rec
);

  br_class_e cls;
  logic      grp_en;
  logic      excluded;

  always_comb begin
    cls = br_class_e'(ret_class);
    case (class_group(cls))
      GRP_SUB: grp_en = en_sub;
      GRP_EXC: grp_en = en_exc;
      default: grp_en = en_normal;
    endcase
    excluded = ret_reset_vec | (is_conditional(cls) & ret_disp_zero);
    accept   = ret_valid & grp_en & ~excluded;
    if (ret_completion && cls == BR_EXC_ENTRY)
      src_rec = ret_src + ADDR_W'(INSN_BYTES);
    else
      src_rec = ret_src;
  end

endmodule

// File: rtl/brtrace_store.sv
module brtrace_store
  import brtrace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_src,
  input  logic [ADDR_W-1:0] wr_dst,
  input  logic              clear,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [CNT_W-1:0]  count,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_src,
  output logic [ADDR_W-1:0] rd_dst
);

  logic [IDX_W-1:0]  wptr_q;
  logic [CNT_W-1:0]  count_q;
  logic [ADDR_W-1:0] src_arr [DEPTH];
  logic [ADDR_W-1:0] dst_arr [DEPTH];
  logic [IDX_W-1:0]  rd_slot;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [ADDR_W-1:0] s_q;
    logic [ADDR_W-1:0] d_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s_q <= '0;
        d_q <= '0;
      end else if (wr_en && wptr_q == IDX_W'(g)) begin
        s_q <= wr_src;
        d_q <= wr_dst;
      end
    end
    assign src_arr[g] = s_q;
    assign dst_arr[g] = d_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      wptr_q  <= '0;
      count_q <= '0;
    end else if (wr_en) begin
      wptr_q <= (wptr_q == IDX_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (count_q != CNT_W'(DEPTH))
        count_q <= count_q + 1'b1;
    end
  end

  always_comb begin
    rd_slot  = IDX_W'(ring_slot(int'(wptr_q), int'(rd_idx), DEPTH));
    rd_valid = CNT_W'(rd_idx) < count_q;
    rd_src   = rd_valid ? src_arr[rd_slot] : '0;
    rd_dst   = rd_valid ? dst_arr[rd_slot] : '0;
  end

  assign count = count_q;

endmodule

// File: rtl/brtrace_ctrl.sv
module brtrace_ctrl #(
  parameter int DEPTH  = 8,
  parameter int LOADS  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int LW    = $clog2(LOADS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cont_mode,
  input  logic             ack_drain,
  input  logic             accept,
  input  logic [CNT_W-1:0] count,
  output logic             wr_fire,
  output logic             drain_clear,
  output logic             stall_req,
  output logic             cont_done
);

  logic          stall_q;
  logic          done_q;
  logic [LW-1:0] loads_q;
  logic          fill_evt;

  assign wr_fire     = accept & ~stall_q & ~done_q;
  assign fill_evt    = cont_mode & wr_fire & (count == CNT_W'(DEPTH - 1));
  assign drain_clear = stall_q & ack_drain;

  always_ff @(posedge clk) begin
    if (!rst_n || !cont_mode) begin
      stall_q <= 1'b0;
      done_q  <= 1'b0;
      loads_q <= '0;
    end else if (fill_evt) begin
      stall_q <= 1'b1;
      loads_q <= loads_q + 1'b1;
    end else if (drain_clear) begin
      stall_q <= 1'b0;
      if (loads_q == LW'(LOADS))
        done_q <= 1'b1;
    end
  end

  assign stall_req = stall_q;
  assign cont_done = done_q;

endmodule

// File: rtl/brtrace_hist.sv
module brtrace_hist
  import brtrace_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DEPTH      = 8,
  parameter int LOADS      = 4,
  parameter int INSN_BYTES = 2,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_valid,
  input  logic [2:0]        ret_class,
  input  logic [ADDR_W-1:0] ret_src,
  input  logic [ADDR_W-1:0] ret_dst,
  input  logic              ret_disp_zero,
  input  logic              ret_reset_vec,
  input  logic              ret_completion,
  input  logic              en_normal,
  input  logic              en_sub,
  input  logic              en_exc,
  input  logic              cont_mode,
  input  logic              ack_drain,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_src,
  output logic [ADDR_W-1:0] rd_dst,
  output logic [CNT_W-1:0]  entry_count,
  output logic              stall_req,
  output logic              cont_done
);

  logic              accept;
  logic              wr_fire;
  logic              drain_clear;
  logic [ADDR_W-1:0] src_rec;

  brtrace_filter #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_filter (
    .ret_valid      (ret_valid),
    .ret_class      (ret_class),
    .ret_src        (ret_src),
    .ret_disp_zero  (ret_disp_zero),
    .ret_reset_vec  (ret_reset_vec),
    .ret_completion (ret_completion),
    .en_normal      (en_normal),
    .en_sub         (en_sub),
    .en_exc         (en_exc),
    .accept         (accept),
    .src_rec        (src_rec)
  );

  brtrace_ctrl #(.DEPTH(DEPTH), .LOADS(LOADS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cont_mode   (cont_mode),
    .ack_drain   (ack_drain),
    .accept      (accept),
    .count       (entry_count),
    .wr_fire     (wr_fire),
    .drain_clear (drain_clear),
    .stall_req   (stall_req),
    .cont_done   (cont_done)
  );

  brtrace_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_fire),
    .wr_src   (src_rec),
    .wr_dst   (ret_dst),
    .clear    (drain_clear),
    .rd_idx   (rd_idx),
    .count    (entry_count),
    .rd_valid (rd_valid),
    .rd_src   (rd_src),
    .rd_dst   (rd_dst)
  );

endmodule

// File: rtl/brtrace_hist_chk.sv
module brtrace_hist_chk #(
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ret_valid,
  input logic [2:0]       ret_class,
  input logic             ret_disp_zero,
  input logic             ret_reset_vec,
  input logic             cont_mode,
  input logic [IDX_W-1:0] rd_idx,
  input logic             rd_valid,
  input logic [CNT_W-1:0] entry_count,
  input logic             stall_req,
  input logic             cont_done,
  input logic             wr_fire,
  input logic             drain_clear
);

  a_r5_no_zero_disp_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_disp_zero && ret_class < 3'd2) |-> !wr_fire);

  a_r6_no_reset_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_reset_vec) |-> !wr_fire);

  a_r8_beyond_count_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (CNT_W'(rd_idx) >= entry_count) |-> !rd_valid);

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    entry_count <= CNT_W'(DEPTH));

  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && entry_count < CNT_W'(DEPTH)) |=> entry_count == $past(entry_count) + 1'b1);

  a_r10_stall_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_mode && wr_fire && entry_count == CNT_W'(DEPTH - 1)) |=> stall_req);

  a_r10_no_write_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> !wr_fire);

  a_r11_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
    drain_clear |=> (entry_count == '0 && !stall_req));

  a_r12_done_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cont_done |-> !wr_fire);

endmodule

bind brtrace_hist brtrace_hist_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ret_valid     (ret_valid),
  .ret_class     (ret_class),
  .ret_disp_zero (ret_disp_zero),
  .ret_reset_vec (ret_reset_vec),
  .cont_mode     (cont_mode),
  .rd_idx        (rd_idx),
  .rd_valid      (rd_valid),
  .entry_count   (entry_count),
  .stall_req     (stall_req),
  .cont_done     (cont_done),
  .wr_fire       (wr_fire),
  .drain_clear   (drain_clear)
);

// File: tb/brtrace_hist_bench.sv
`timescale 1ns/1ps
module brtrace_hist_bench;

  localparam int DEPTH = 8;
  localparam int LOADS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ret_valid = 1'b0;
  logic [2:0]  ret_class = '0;
  logic [31:0] ret_src = '0;
  logic [31:0] ret_dst = '0;
  logic        ret_disp_zero = 1'b0;
  logic        ret_reset_vec = 1'b0;
  logic        ret_completion = 1'b0;
  logic        en_normal = 1'b1;
  logic        en_sub = 1'b1;
  logic        en_exc = 1'b1;
  logic        cont_mode = 1'b0;
  logic        ack_drain = 1'b0;
  logic [2:0]  rd_idx = '0;
  logic        rd_valid;
  logic [31:0] rd_src;
  logic [31:0] rd_dst;
  logic [3:0]  entry_count;
  logic        stall_req;
  logic        cont_done;

  always #2.5 clk = ~clk;

  brtrace_hist u_brtrace_hist (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_class(ret_class),
    .ret_src(ret_src), .ret_dst(ret_dst), .ret_disp_zero(ret_disp_zero),
    .ret_reset_vec(ret_reset_vec), .ret_completion(ret_completion),
    .en_normal(en_normal), .en_sub(en_sub), .en_exc(en_exc),
    .cont_mode(cont_mode), .ack_drain(ack_drain), .rd_idx(rd_idx),
    .rd_valid(rd_valid), .rd_src(rd_src), .rd_dst(rd_dst),
    .entry_count(entry_count), .stall_req(stall_req), .cont_done(cont_done)
  );

  // Expected history, newest at the front.
  logic [31:0] exp_src[$];
  logic [31:0] exp_dst[$];
  bit m_stall, m_done;
  int m_loads;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor side of the scoreboard: walk every index, newest first.
  task automatic check_all(string req);
    cmp(req, "entry_count", 32'(entry_count), 32'(exp_src.size()));
    cmp(req, "stall_req", 32'(stall_req), 32'(m_stall));
    cmp(req, "cont_done", 32'(cont_done), 32'(m_done));
    for (int i = 0; i < DEPTH; i++) begin
      bit v;
      rd_idx = 3'(i);
      #0.2;
      v = i < exp_src.size();
      cmp(req, $sformatf("rd_valid[%0d]", i), 32'(rd_valid), 32'(v));
      cmp(req, $sformatf("rd_src[%0d]", i), rd_src, v ? exp_src[i] : 32'h0);
      cmp(req, $sformatf("rd_dst[%0d]", i), rd_dst, v ? exp_dst[i] : 32'h0);
    end
  endtask

  // Driver side: apply one strobe and push the expected pair.
  task automatic retire(int cls, logic [31:0] s, logic [31:0] d,
                        bit dz = 0, bit rv = 0, bit comp = 0);
    bit en, keep;
    @(negedge clk);
    ret_valid = 1; ret_class = 3'(cls); ret_src = s; ret_dst = d;
    ret_disp_zero = dz; ret_reset_vec = rv; ret_completion = comp;
    en = (cls >= 6) ? en_exc : (cls >= 4) ? en_sub : en_normal;
    keep = en && !rv && !(cls < 2 && dz) && !m_stall && !m_done;
    @(posedge clk);
    if (keep) begin
      exp_src.push_front((comp && cls == 7) ? s + 32'd2 : s);
      exp_dst.push_front(d);
      if (exp_src.size() > DEPTH) begin
        void'(exp_src.pop_back());
        void'(exp_dst.pop_back());
      end
      if (cont_mode && exp_src.size() == DEPTH) begin
        m_stall = 1;
        m_loads++;
      end
    end
    @(negedge clk);
    ret_valid = 0; ret_disp_zero = 0; ret_reset_vec = 0; ret_completion = 0;
  endtask

  task automatic drain();
    @(negedge clk);
    ack_drain = 1;
    @(posedge clk);
    if (m_stall) begin
      exp_src.delete(); exp_dst.delete();
      m_stall = 0;
      if (m_loads == LOADS) m_done = 1;
    end
    @(negedge clk);
    ack_drain = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    exp_src.delete(); exp_dst.delete();
    m_stall = 0; m_done = 0; m_loads = 0;
  endtask

  task automatic set_cont(bit v);
    @(negedge clk);
    cont_mode = v;
    if (!v) begin m_stall = 0; m_done = 0; m_loads = 0; end
    @(negedge clk);
  endtask

  initial begin
    do_reset();
    check_all("R1");

    retire(0, 32'h100, 32'h200);
    retire(1, 32'h110, 32'h210);
    retire(2, 32'h120, 32'h220);
    retire(3, 32'h130, 32'h230);
    check_all("R2");
    en_normal = 0;
    retire(2, 32'h140, 32'h240);
    check_all("R2");
    en_normal = 1;

    retire(4, 32'h300, 32'h400);
    retire(5, 32'h310, 32'h410, 0, 0, 1);   // completion flag ignored off class 7
    check_all("R3");
    en_sub = 0;
    retire(4, 32'h320, 32'h420);
    check_all("R3");
    en_sub = 1;

    retire(6, 32'h500, 32'h600);
    retire(7, 32'h510, 32'h610);
    check_all("R4");
    en_exc = 0;
    retire(7, 32'h520, 32'h620);
    check_all("R4");
    en_exc = 1;

    retire(0, 32'h700, 32'h700, 1);
    retire(1, 32'h710, 32'h710, 1);
    check_all("R5");
    retire(2, 32'h720, 32'h720, 1);
    check_all("R5");

    retire(7, 32'hA000_0000, 32'hA000_0000, 0, 1);
    retire(4, 32'h730, 32'h830, 0, 1);
    check_all("R6");

    retire(7, 32'h1000, 32'h8000, 0, 0, 1);
    check_all("R7");

    for (int i = 0; i < 10; i++) begin
      retire(i % 8, 32'h2000 + 32'(i * 4), 32'h3000 + 32'(i * 4));
      check_all("R9");
    end
    check_all("R8");

    do_reset();
    set_cont(1);
    for (int l = 0; l < LOADS; l++) begin
      for (int k = 0; k < DEPTH; k++)
        retire(2, 32'h4000 + 32'(l * 64 + k), 32'h5000 + 32'(l * 64 + k));
      check_all("R10");
      retire(3, 32'hDEAD, 32'hBEEF);
      check_all("R10");
      drain();
      check_all("R11");
    end
    check_all("R12");
    retire(2, 32'h6000, 32'h6100);
    check_all("R12");
    set_cont(0);
    retire(2, 32'h6200, 32'h6300);
    check_all("R12");

    finish_run();
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule